// File: doc/BRIEF.md
# PCI DMA Write Posting Buffer

This block sits behind the target side of a PCI host bridge and absorbs inbound memory-write bursts into a small pool of cache-line entries. There are four of them by default. Each entry holds a line address, eight 32-bit words, a 4-bit byte-enable group per word and a committed flag. The memory side can then retire those entries at its own pace. Writes from the PCI initiator are posted, so the bus is released as soon as the data has been captured.

A burst begins with a one-cycle address strobe. Data beats follow, and the block fills words in ascending order starting from the word offset of the start address. A line is committed when its last word is written, or earlier when the initiator marks its final beat. A burst may run across two adjacent lines, and the pair must begin at an even line boundary, so the longest burst is sixteen words. The block ends a burst itself by raising a disconnect together with the last beat it takes. It does this when the burst reaches the end of the line pair, or when the next line has no free entry. If every entry is committed when a burst begins, the block asks for a retry.

The fill controller has three states. `ST_IDLE` waits for the address strobe. `ST_FILL` takes beats. `ST_RETRY` is the one-cycle refusal. The transitions are:

- `ST_IDLE` to `ST_FILL` on a strobe with an entry free.
- `ST_IDLE` to `ST_RETRY` on a strobe with all entries committed.
- `ST_RETRY` back to `ST_IDLE` after one cycle.
- `ST_FILL` back to `ST_IDLE` on a beat that carries the final-beat mark or the disconnect.
- Every other case holds the current state.

Top module: `dma_wpost_buf`

## Requirements
- R1: While reset is held and directly after it, `mem_valid`, `in_ready` and `in_disc` are all low.
- R2: After an address strobe that finds a free entry, `in_ready` is high from the next cycle. Each beat writes its data and byte enables into the word named by address bits 4:2 of the start address, counted upward one word per beat.
- R3: A burst whose start address has bits 5:2 all zero takes exactly sixteen beats. `in_disc` is high together with the sixteenth beat, and `in_ready` is low in the cycle after that beat.
- R4: A burst that starts with address bits 5:2 equal to k takes at most 16 - k beats, with `in_disc` on the last of them. When bit 5 is set, the burst therefore ends at the end of that same line.
- R5: A beat with `in_last` high ends the burst without `in_disc` and commits a partial line. Words of that line that were never written show byte enables of 0 at the memory side.
- R6: At the last word of the first line of a pair, if the committed-entry count plus one reaches the depth, the block raises `in_disc` on that beat instead of continuing.
- R7: An address strobe while all entries are committed gives exactly one cycle with `in_disc` high and `in_ready` low. No data is stored.
- R8: Committed lines leave in the order they were committed. `mem_valid`, `mem_laddr`, `mem_data` and `mem_be` hold steady until `mem_ack` is sampled high, and the acknowledge retires that entry.
- R9: A line commit and a memory acknowledge in the same cycle each take effect, so the committed count stays exact.
- R10: `mem_laddr` equals start address bits 31:5 for the first line of a burst, and that value plus one for the second line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_start | input | 1 | Address strobe that opens a burst |
| in_addr | input | 32 | Start byte address, sampled with `in_start` |
| in_valid | input | 1 | Data beat present |
| in_data | input | 32 | Beat data |
| in_be | input | 4 | Beat byte enables, active high |
| in_last | input | 1 | Initiator's final beat |
| in_ready | output | 1 | Beats are taken while high |
| in_disc | output | 1 | Target ends the burst after this beat, or refuses it (retry) |
| mem_valid | output | 1 | Oldest committed line is presented |
| mem_laddr | output | 27 | Line address of the presented line |
| mem_data | output | 256 | Eight words of the line, word 0 in the low bits |
| mem_be | output | 32 | Byte enables of the line, 4 per word, word 0 in the low bits |
| mem_ack | input | 1 | Memory side takes the presented line |

## Verification
A line commit from the PCI side and a retirement from the memory side can land on the same clock edge, and both move the committed count. The bench first leaves two entries waiting. It then raises `mem_ack` for exactly the cycle in which a following burst writes word 7 of its first line. Afterwards it runs a third aligned burst. With a correct count, that burst has to stop after eight beats because no entry is left. A lost commit or a lost retirement would change this stop point, and the scoreboard would also see the line order disturbed.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    // byte enables carried per 32-bit word
    localparam int BE_W = 4;

    // fill controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_RETRY = 2'd2
    } fill_st_t;

endpackage

// File: rtl/wpb_fill_fsm.sv
module wpb_fill_fsm
    import wpb_pkg::*;
#(
    parameter  int DEPTH  = 4,
    parameter  int WORDS  = 8,
    parameter  int ADDR_W = 32,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int OFF_W  = WIDX_W + 2,
    localparam int LA_W   = ADDR_W - OFF_W,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_start,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [CNT_W-1:0]  vcount,
    output fill_st_t          st,
    output logic              in_ready,
    output logic              in_disc,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_slot,
    output logic [WIDX_W-1:0] wr_word,
    output logic              alloc_en,
    output logic [PTR_W-1:0]  alloc_slot,
    output logic [LA_W-1:0]   alloc_laddr,
    output logic              commit_en,
    output logic [PTR_W-1:0]  commit_slot
);

    fill_st_t          st_q, st_d;
    logic [PTR_W-1:0]  tail_q, tail_nx;
    logic [WIDX_W-1:0] word_q;
    logic              odd_q;
    logic [LA_W-1:0]   laddr_q;

    logic              beat, line_end, no_room, full;
    logic              start_ok, disc_beat, carry_on;
    logic [CNT_W:0]    cnt_plus;

    assign tail_nx  = (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
    assign cnt_plus = {1'b0, vcount} + 1'b1;
    assign no_room  = cnt_plus >= (CNT_W + 1)'(DEPTH);
    assign full     = vcount == CNT_W'(DEPTH);
    assign beat     = (st_q == ST_FILL) && in_valid;
    assign line_end = word_q == WIDX_W'(WORDS - 1);
    assign start_ok = (st_q == ST_IDLE) && in_start && !full;

    // line pair exhausted, or the following line has nowhere to go
    assign disc_beat = beat && line_end && !in_last && (odd_q || no_room);
    assign carry_on  = beat && line_end && !in_last && !odd_q && !no_room;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (in_start) st_d = full ? ST_RETRY : ST_FILL;
            end
            ST_FILL: begin
                if (beat && (in_last || disc_beat)) st_d = ST_IDLE;
            end
            ST_RETRY: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        st          = st_q;
        in_ready    = st_q == ST_FILL;
        in_disc     = disc_beat || (st_q == ST_RETRY);
        wr_en       = beat;
        wr_slot     = tail_q;
        wr_word     = word_q;
        commit_en   = beat && (line_end || in_last);
        commit_slot = tail_q;
        alloc_en    = start_ok || carry_on;
        alloc_slot  = start_ok ? tail_q : tail_nx;
        alloc_laddr = start_ok ? in_addr[ADDR_W-1:OFF_W] : laddr_q + 1'b1;
    end

    // word position, pair half, line address and fill slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q  <= '0;
            word_q  <= '0;
            odd_q   <= 1'b0;
            laddr_q <= '0;
        end else begin
            if (start_ok) begin
                word_q  <= in_addr[OFF_W-1:2];
                odd_q   <= in_addr[OFF_W];
                laddr_q <= in_addr[ADDR_W-1:OFF_W];
            end else if (beat) begin
                word_q <= word_q + 1'b1;
                if (line_end) begin
                    odd_q   <= ~odd_q;
                    laddr_q <= laddr_q + 1'b1;
                end
            end
            if (commit_en) tail_q <= tail_nx;
        end
    end

endmodule

// File: rtl/wpb_line_store.sv
module wpb_line_store
    import wpb_pkg::*;
#(
    parameter  int DEPTH  = 4,
    parameter  int WORDS  = 8,
    parameter  int DATA_W = 32,
    parameter  int LA_W   = 27,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_en,
    input  logic [PTR_W-1:0]        alloc_slot,
    input  logic [LA_W-1:0]         alloc_laddr,
    input  logic                    wr_en,
    input  logic [PTR_W-1:0]        wr_slot,
    input  logic [WIDX_W-1:0]       wr_word,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [BE_W-1:0]         wr_be,
    input  logic                    commit_en,
    input  logic [PTR_W-1:0]        commit_slot,
    input  logic                    pop_en,
    input  logic [PTR_W-1:0]        pop_slot,
    input  logic [PTR_W-1:0]        rd_slot,
    output logic                    rd_vld,
    output logic [LA_W-1:0]         rd_laddr,
    output logic [WORDS*DATA_W-1:0] rd_data,
    output logic [WORDS*BE_W-1:0]   rd_be
);

    logic [DEPTH-1:0]                 ent_vld;
    logic [LA_W-1:0]                  ent_laddr [DEPTH];
    logic [WORDS-1:0][BE_W-1:0]       ent_be    [DEPTH];
    logic [WORDS-1:0][DATA_W-1:0]     ent_data  [DEPTH];

    // valid flags, addresses and byte enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_vld <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                ent_laddr[e] <= '0;
                ent_be[e]    <= '0;
            end
        end else begin
            if (alloc_en) begin
                ent_laddr[alloc_slot] <= alloc_laddr;
                ent_be[alloc_slot]    <= '0;
            end
            if (wr_en) ent_be[wr_slot][wr_word] <= wr_be;
            if (commit_en) ent_vld[commit_slot] <= 1'b1;
            if (pop_en)    ent_vld[pop_slot]    <= 1'b0;
        end
    end

    // data words need no reset: byte enables qualify them
    always_ff @(posedge clk) begin
        if (wr_en) ent_data[wr_slot][wr_word] <= wr_data;
    end

    assign rd_vld   = ent_vld[rd_slot];
    assign rd_laddr = ent_laddr[rd_slot];

    for (genvar w = 0; w < WORDS; w++) begin : g_rd
        assign rd_data[w*DATA_W +: DATA_W] = ent_data[rd_slot][w];
        assign rd_be[w*BE_W +: BE_W]       = ent_be[rd_slot][w];
    end

endmodule

// File: rtl/wpb_drain_ctrl.sv
module wpb_drain_ctrl #(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_en,
    input  logic             head_vld,
    input  logic             mem_ack,
    output logic             pop_en,
    output logic [PTR_W-1:0] head,
    output logic [CNT_W-1:0] vcount
);

    assign pop_en = head_vld && mem_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head   <= '0;
            vcount <= '0;
        end else begin
            if (pop_en) head <= (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
            unique case ({commit_en, pop_en})
                2'b10:   vcount <= vcount + 1'b1;
                2'b01:   vcount <= vcount - 1'b1;
                default: vcount <= vcount;
            endcase
        end
    end

endmodule

// File: rtl/dma_wpost_buf.sv
module dma_wpost_buf
    import wpb_pkg::*;
#(
    parameter  int DEPTH  = 4,
    parameter  int WORDS  = 8,
    parameter  int DATA_W = 32,
    parameter  int ADDR_W = 32,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LA_W   = ADDR_W - WIDX_W - 2,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_start,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    input  logic [BE_W-1:0]         in_be,
    input  logic                    in_last,
    output logic                    in_ready,
    output logic                    in_disc,
    output logic                    mem_valid,
    output logic [LA_W-1:0]         mem_laddr,
    output logic [WORDS*DATA_W-1:0] mem_data,
    output logic [WORDS*BE_W-1:0]   mem_be,
    input  logic                    mem_ack
);

    fill_st_t          st;
    logic              wr_en, alloc_en, commit_en, pop_en;
    logic [PTR_W-1:0]  wr_slot, alloc_slot, commit_slot, head;
    logic [WIDX_W-1:0] wr_word;
    logic [LA_W-1:0]   alloc_laddr;
    logic [CNT_W-1:0]  vcount;

    wpb_fill_fsm #(.DEPTH(DEPTH), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_start    (in_start),
        .in_addr     (in_addr),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .vcount      (vcount),
        .st          (st),
        .in_ready    (in_ready),
        .in_disc     (in_disc),
        .wr_en       (wr_en),
        .wr_slot     (wr_slot),
        .wr_word     (wr_word),
        .alloc_en    (alloc_en),
        .alloc_slot  (alloc_slot),
        .alloc_laddr (alloc_laddr),
        .commit_en   (commit_en),
        .commit_slot (commit_slot)
    );

    wpb_line_store #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .LA_W(LA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (alloc_en),
        .alloc_slot  (alloc_slot),
        .alloc_laddr (alloc_laddr),
        .wr_en       (wr_en),
        .wr_slot     (wr_slot),
        .wr_word     (wr_word),
        .wr_data     (in_data),
        .wr_be       (in_be),
        .commit_en   (commit_en),
        .commit_slot (commit_slot),
        .pop_en      (pop_en),
        .pop_slot    (head),
        .rd_slot     (head),
        .rd_vld      (mem_valid),
        .rd_laddr    (mem_laddr),
        .rd_data     (mem_data),
        .rd_be       (mem_be)
    );

    wpb_drain_ctrl #(.DEPTH(DEPTH)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_en (commit_en),
        .head_vld  (mem_valid),
        .mem_ack   (mem_ack),
        .pop_en    (pop_en),
        .head      (head),
        .vcount    (vcount)
    );

endmodule

// File: rtl/wpb_chk.sv
module wpb_chk
    import wpb_pkg::*;
#(
    parameter  int DEPTH  = 4,
    parameter  int WORDS  = 8,
    parameter  int DATA_W = 32,
    parameter  int LA_W   = 27,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int BC_W   = $clog2(2 * WORDS) + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_start,
    input logic                    in_valid,
    input logic                    in_last,
    input logic                    in_ready,
    input logic                    in_disc,
    input logic                    mem_valid,
    input logic                    mem_ack,
    input logic [LA_W-1:0]         mem_laddr,
    input logic [WORDS*DATA_W-1:0] mem_data,
    input logic [WORDS*BE_W-1:0]   mem_be,
    input fill_st_t                st,
    input logic                    commit_en,
    input logic [CNT_W-1:0]        vcount
);

    logic [BC_W-1:0] beat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    beat_cnt <= '0;
        else if (!in_ready)            beat_cnt <= '0;
        else if (in_valid)             beat_cnt <= beat_cnt + 1'b1;
    end

    // R3
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> beat_cnt < BC_W'(2 * WORDS));

    // R3
    disc_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_disc |=> !in_ready);

    // R5
    last_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |-> !in_disc);

    // R7
    retry_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_start && st == ST_IDLE && vcount == CNT_W'(DEPTH) |=> in_disc && !in_ready);

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ack |=> mem_valid && $stable(mem_laddr)
                                  && $stable(mem_data) && $stable(mem_be));

    // R9
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ack && !commit_en |=> vcount == $past(vcount) - 1'b1);

    // R9
    both_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ack && commit_en |=> $stable(vcount));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcount <= CNT_W'(DEPTH));

endmodule

bind dma_wpost_buf wpb_chk #(
    .DEPTH (DEPTH),
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .LA_W  (LA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_start  (in_start),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .in_disc   (in_disc),
    .mem_valid (mem_valid),
    .mem_ack   (mem_ack),
    .mem_laddr (mem_laddr),
    .mem_data  (mem_data),
    .mem_be    (mem_be),
    .st        (st),
    .commit_en (commit_en),
    .vcount    (vcount)
);

// File: tb/tb_dma_wpost_buf.sv
module tb_dma_wpost_buf;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 8;
    localparam int DATA_W     = 32;
    localparam int LA_W       = 27;

    typedef struct packed {
        logic [LA_W-1:0]         la;
        logic [WORDS*DATA_W-1:0] d;
        logic [WORDS*4-1:0]      b;
    } line_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_start = 1'b0;
    logic [31:0]             in_addr = '0;
    logic                    in_valid = 1'b0;
    logic [31:0]             in_data = '0;
    logic [3:0]              in_be = '0;
    logic                    in_last = 1'b0;
    logic                    in_ready, in_disc, mem_valid;
    logic [LA_W-1:0]         mem_laddr;
    logic [WORDS*DATA_W-1:0] mem_data;
    logic [WORDS*4-1:0]      mem_be;
    logic                    mem_ack = 1'b0;

    line_t exp_q[$];
    line_t got;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    ack_on = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_wpost_buf dut (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_addr(in_addr),
        .in_valid(in_valid), .in_data(in_data), .in_be(in_be), .in_last(in_last),
        .in_ready(in_ready), .in_disc(in_disc), .mem_valid(mem_valid),
        .mem_laddr(mem_laddr), .mem_data(mem_data), .mem_be(mem_be), .mem_ack(mem_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: pops and compares each retired line
    always @(negedge clk) begin
        if (rst_n && mem_valid && ack_on) begin
            mem_ack = 1'b1;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected line", 64'(mem_laddr), 64'h0);
            end else begin
                got = exp_q.pop_front();
                chk(mem_laddr == got.la, "R10", "line address", 64'(mem_laddr), 64'(got.la));
                chk(mem_be == got.b, "R5", "byte enables", 64'(mem_be), 64'(got.b));
                for (int w = 0; w < WORDS; w++) begin
                    if (got.b[w*4 +: 4] != 4'h0)
                        chk(mem_data[w*DATA_W +: DATA_W] == got.d[w*DATA_W +: DATA_W],
                            "R2", "word data", 64'(mem_data[w*DATA_W +: DATA_W]),
                            64'(got.d[w*DATA_W +: DATA_W]));
                end
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    // driver: runs one burst and pushes the expected lines
    task automatic burst(input logic [31:0] a, input int n, input int exp_acc,
                         input int ack_beat, input string req);
        int              acc = 0;
        bit              dc_seen = 1'b0;
        bit              nl = 1'b1;
        int              w = int'(a[4:2]);
        logic [LA_W-1:0] la = a[31:5];
        line_t           cur = '0;
        @(negedge clk);
        in_start = 1'b1;
        in_addr  = a;
        @(negedge clk);
        in_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = 32'hC0DE0000 ^ (a << 4) ^ 32'(i);
            in_be    = 4'((i * 7) % 15 + 1);
            in_last  = (i == n - 1);
            #1;
            if (!in_ready) begin
                chk(1'b0, "R2", "beat refused", 64'(i), 64'h0);
                break;
            end
            acc++;
            if (nl) begin
                cur.la = la;
                cur.d  = '0;
                cur.b  = '0;
                nl     = 1'b0;
            end
            cur.d[w*DATA_W +: DATA_W] = in_data;
            cur.b[w*4 +: 4]           = in_be;
            if (in_disc) dc_seen = 1'b1;
            if (w == WORDS - 1 || in_last || in_disc) begin
                exp_q.push_back(cur);
                nl = 1'b1;
            end
            if (i + 1 == ack_beat) ack_on = 1'b1;
            if (i == ack_beat)     ack_on = 1'b0;
            w = (w + 1) % WORDS;
            if (w == 0) la = la + 1'b1;
            @(negedge clk);
            if (dc_seen) break;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        #1;
        chk(acc == exp_acc, req, "accepted beats", 64'(acc), 64'(exp_acc));
        chk(dc_seen == (exp_acc < n), req, "disconnect seen", 64'(dc_seen), 64'(exp_acc < n));
        chk(!in_ready, req, "ready after burst", 64'(in_ready), 64'h0);
    endtask

    task automatic retry(input logic [31:0] a);
        @(negedge clk);
        in_start = 1'b1;
        in_addr  = a;
        @(negedge clk);
        in_start = 1'b0;
        #1;
        chk(in_disc && !in_ready, "R7", "retry signalled", {in_disc, in_ready}, 64'h2);
        @(negedge clk);
        #1;
        chk(!in_disc && !in_ready, "R7", "retry one cycle", {in_disc, in_ready}, 64'h0);
    endtask

    task automatic drain();
        ack_on = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !mem_valid) break;
        end
        #1;
        chk(exp_q.size() == 0, "R8", "lines left expected", 64'(exp_q.size()), 64'h0);
        chk(!mem_valid, "R8", "buffer empty", 64'(mem_valid), 64'h0);
        ack_on = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog expired: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk(!mem_valid && !in_ready && !in_disc, "R1", "reset outputs",
            {mem_valid, in_ready, in_disc}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!mem_valid && !in_ready && !in_disc, "R1", "after reset",
            {mem_valid, in_ready, in_disc}, 64'h0);

        ack_on = 1'b1;
        burst(32'h0000_1000, 20, 16, -1, "R3");
        burst(32'h0000_200C, 20, 13, -1, "R4");
        burst(32'h0000_3024, 20, 7,  -1, "R4");
        burst(32'h0000_4008, 3,  3,  -1, "R5");
        drain();

        // entries held back: fill to capacity
        ack_on = 1'b0;
        burst(32'h0000_5000, 16, 16, -1, "R3");
        burst(32'h0000_6010, 4,  4,  -1, "R5");
        burst(32'h0000_7000, 16, 8,  -1, "R6");
        retry(32'h0000_8000);
        @(negedge clk);
        #1;
        chk(mem_valid && mem_laddr == LA_W'(32'h5000 >> 5), "R8", "oldest line held",
            64'(mem_laddr), 64'(32'h5000 >> 5));
        drain();

        // R9: commit and retirement on the same edge
        burst(32'h0000_9000, 16, 16, -1, "R9");
        burst(32'h0000_A000, 16, 16, 7,  "R9");
        burst(32'h0000_B000, 16, 8,  -1, "R9");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule